// File: doc/BRIEF.md
# Indirect Sequencer Memory Port

This block puts a 256-byte power-sequencing store behind two register addresses: a pointer and a data window. The store holds 64 entries of 4 bytes. The pointer packs the entry index and the byte lane into one byte. Software sets the pointer once and then streams bytes through the data window, because every data write moves the pointer on by one.

Writes through the window are filtered in two ways. A fixed protection map decides which entry and lane pairs may change at all. An external configuration-unlock input must also be high for any byte to be stored. A blocked write still advances the pointer, so a stream of writes stays aligned with the layout whether or not its bytes land. Reading the window returns the byte under the pointer and leaves the pointer where it is.

Top module: `seq_mem_port`

## Requirements
- R1: While `rst` is high, the pointer is cleared to 0x00 and `reg_rdata` is 0. After reset, every byte of the store reads as 0x00 until it is written.
- R2: Register address 0 is the pointer. A write there loads all 8 bits of the pointer. A read there returns the current pointer value.
- R3: Each write to register address 1 (the data window) advances the pointer by one, wrapping from 0xFF to 0x00. This happens whether or not the byte is stored.
- R4: Pointer bits [7:2] are the entry index and bits [1:0] are the byte lane. For entries 0x2b through 0x3e, all four lanes are writable. A write stores `reg_wdata` at the location under the pointer before the pointer advances.
- R5: For entries 0x00 through 0x0e, only lane 3 is writable. Every other entry and lane pair is protected, and a write to it leaves the stored byte unchanged.
- R6: While `cfg_unlock` is low, data-window writes store nothing, but they still advance the pointer.
- R7: A read of the data window returns the byte at the pointer location without changing the pointer. The value appears on `reg_rdata` at the clock edge that samples the address.
- R8: Register addresses 2 and 3 read as 0x00. Writes to them change neither the pointer nor the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_unlock | input | 1 | Configuration unlock; must be high for data-window writes to store |
| reg_addr | input | 2 | Register select: 0 = pointer, 1 = data window |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address sampled at the last edge |

## Verification
The bench builds the block with its default parameters: 6 entry-index bits, 2 lane bits, an 8-bit data path, a writable window of entries 0x2b to 0x3e, and lane-3-only writes for entries up to 0x0e. With an 8-bit pointer, the wrap from 0xFF to 0x00 can be reached in a single write. Both edges of the writable window, and the entries just outside them, are a few pointer loads apart. This lets the bench probe every protection boundary, the pointer wrap, and behaviour while locked, all directly.

// File: rtl/seqport_pkg.sv
package seqport_pkg;
  // Register select encodings at the block edge
  localparam int unsigned REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] SEL_PTR  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] SEL_DATA = 2'd1;
endpackage

// File: rtl/seqport_ptr.sv
module seqport_ptr #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + 1'b1;
  end

  // R1: pointer is zero after a reset cycle
  a_r1_ptr_reset: assert property (@(posedge clk) rst |=> ptr == '0);

  // R2: a pointer write takes the written value
  a_r2_ptr_load: assert property (@(posedge clk) disable iff (rst)
    load |=> ptr == $past(load_val));

  // R3: a data write advances the pointer by one, modulo its width
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> ptr == PTR_W'($past(ptr) + 1'b1));
endmodule

// File: rtl/seqport_guard.sv
module seqport_guard #(
  parameter int unsigned ENTRY_W   = 6,
  parameter int unsigned LANE_W    = 2,
  parameter int unsigned OPEN_LO   = 'h2b,
  parameter int unsigned OPEN_HI   = 'h3e,
  parameter int unsigned TAIL_MAX  = 'h0e,
  parameter int unsigned TAIL_LANE = 3,
  localparam int unsigned PTR_W    = ENTRY_W + LANE_W
) (
  input  logic [PTR_W-1:0] ptr,
  output logic             allow
);
  logic [ENTRY_W-1:0] entry;
  logic [LANE_W-1:0]  lane;
  logic               in_window;
  logic               in_tail;

  assign entry = ptr[PTR_W-1:LANE_W];
  assign lane  = ptr[LANE_W-1:0];

  always_comb begin
    in_window = (32'(entry) >= OPEN_LO) && (32'(entry) <= OPEN_HI);
    in_tail   = (32'(entry) <= TAIL_MAX) && (32'(lane) == TAIL_LANE);
    allow     = in_window || in_tail;
  end
endmodule

// File: rtl/seqport_store.sv
module seqport_store #(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rbyte
);
  // Array without reset so it maps onto RAM; a flag vector masks stale data
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  filled;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     filled <= '0;
    else if (we) filled[waddr] <= 1'b1;
  end

  assign rbyte = filled[raddr] ? mem[raddr] : '0;

  // R4: a committed write marks its location as holding data
  a_r4_fill_on_write: assert property (@(posedge clk) disable iff (rst)
    we |=> filled[$past(waddr)]);
endmodule

// File: rtl/seq_mem_port.sv
module seq_mem_port
  import seqport_pkg::*;
#(
  parameter int unsigned ENTRY_W   = 6,
  parameter int unsigned LANE_W    = 2,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OPEN_LO   = 'h2b,
  parameter int unsigned OPEN_HI   = 'h3e,
  parameter int unsigned TAIL_MAX  = 'h0e,
  parameter int unsigned TAIL_LANE = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_unlock,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata
);
  localparam int unsigned PTR_W = ENTRY_W + LANE_W;

  logic             hit_ptr, hit_data;
  logic             ptr_load, ptr_step, allow, commit;
  logic [PTR_W-1:0] ptr;
  logic [DATA_W-1:0] cur_byte;

  assign hit_ptr  = (reg_addr == SEL_PTR);
  assign hit_data = (reg_addr == SEL_DATA);
  assign ptr_load = reg_wr && hit_ptr;
  assign ptr_step = reg_wr && hit_data;
  assign commit   = ptr_step && cfg_unlock && allow;

  seqport_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load),
    .load_val(reg_wdata[PTR_W-1:0]), .step(ptr_step), .ptr(ptr)
  );

  seqport_guard #(
    .ENTRY_W(ENTRY_W), .LANE_W(LANE_W), .OPEN_LO(OPEN_LO), .OPEN_HI(OPEN_HI),
    .TAIL_MAX(TAIL_MAX), .TAIL_LANE(TAIL_LANE)
  ) u_guard (
    .ptr(ptr), .allow(allow)
  );

  seqport_store #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .we(commit), .waddr(ptr), .wdata(reg_wdata),
    .raddr(ptr), .rbyte(cur_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (hit_ptr) reg_rdata <= DATA_W'(ptr);
    else if (hit_data) reg_rdata <= cur_byte;
    else reg_rdata <= '0;
  end

  // R1: read data is zero after a reset cycle
  a_r1_rdata_reset: assert property (@(posedge clk) rst |=> reg_rdata == '0);
endmodule

// File: tb/seq_mem_port_test.sv
module seq_mem_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_unlock = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  seq_mem_port uut (
    .clk(clk), .rst(rst), .cfg_unlock(cfg_unlock), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(posedge clk); #1;
    v = reg_rdata;
  endtask

  task automatic peek(input logic [7:0] p, output logic [7:0] v);
    wr(2'd0, p);
    rd(2'd1, v);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1; chk("R1 rdata in reset", reg_rdata, 8'h00);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 pointer after reset", v, 8'h00);
    rd(2'd1, v); chk("R1 byte 0 after reset", v, 8'h00);
    peek(8'hAC, v); chk("R1 window byte after reset", v, 8'h00);
    wr(2'd0, 8'h5D); rd(2'd0, v); chk("R2 pointer readback", v, 8'h5D);
  endtask

  task automatic t_window();
    logic [7:0] v;
    wr(2'd0, 8'hAC);
    for (int i = 0; i < 4; i++) wr(2'd1, 8'h11 * (i + 1));
    rd(2'd0, v); chk("R3 pointer after 4 writes", v, 8'hB0);
    peek(8'hAC, v); chk("R4 entry 0x2b lane 0", v, 8'h11);
    rd(2'd1, v); chk("R7 repeat read same byte", v, 8'h11);
    rd(2'd0, v); chk("R7 read leaves pointer", v, 8'hAC);
    peek(8'hAF, v); chk("R4 entry 0x2b lane 3", v, 8'h44);
  endtask

  task automatic t_upper_edge();
    logic [7:0] v;
    wr(2'd0, 8'hF8);
    for (int i = 0; i < 4; i++) wr(2'd1, 8'hA0 + 8'(i));
    wr(2'd1, 8'hEE);
    rd(2'd0, v); chk("R3 pointer past blocked write", v, 8'hFD);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h55);
    rd(2'd0, v); chk("R3 pointer wraps to 0", v, 8'h00);
    peek(8'hF8, v); chk("R4 entry 0x3e lane 0", v, 8'hA0);
    peek(8'hFB, v); chk("R4 entry 0x3e lane 3", v, 8'hA3);
    peek(8'hFC, v); chk("R5 entry 0x3f blocked", v, 8'h00);
    peek(8'hFF, v); chk("R5 entry 0x3f lane 3 blocked", v, 8'h00);
  endtask

  task automatic t_lower_edge();
    logic [7:0] v;
    wr(2'd0, 8'hAB); wr(2'd1, 8'h77);
    rd(2'd0, v); chk("R3 pointer after blocked 0x2a", v, 8'hAC);
    peek(8'hAB, v); chk("R5 entry 0x2a lane 3 blocked", v, 8'h00);
    peek(8'hAC, v); chk("R5 neighbour unchanged", v, 8'h11);
  endtask

  task automatic t_tail();
    logic [7:0] v;
    wr(2'd0, 8'h3B); wr(2'd1, 8'h5A);
    wr(2'd0, 8'h3A); wr(2'd1, 8'h66);
    wr(2'd0, 8'h3F); wr(2'd1, 8'h67);
    wr(2'd0, 8'h03); wr(2'd1, 8'h99);
    peek(8'h3B, v); chk("R5 entry 0x0e lane 3 writable", v, 8'h5A);
    peek(8'h3A, v); chk("R5 entry 0x0e lane 2 blocked", v, 8'h00);
    peek(8'h3F, v); chk("R5 entry 0x0f lane 3 blocked", v, 8'h00);
    peek(8'h03, v); chk("R5 entry 0x00 lane 3 writable", v, 8'h99);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    cfg_unlock = 1'b0;
    wr(2'd0, 8'hB4); wr(2'd1, 8'h42);
    rd(2'd0, v); chk("R6 pointer advances while locked", v, 8'hB5);
    peek(8'hB4, v); chk("R6 locked write discarded", v, 8'h00);
    cfg_unlock = 1'b1;
    wr(2'd1, 8'h43);
    peek(8'hB4, v); chk("R6 write after unlock stored", v, 8'h43);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    wr(2'd0, 8'hB4);
    wr(2'd2, 8'h10); wr(2'd3, 8'h20);
    rd(2'd0, v); chk("R8 pointer unchanged by unused writes", v, 8'hB4);
    rd(2'd1, v); chk("R8 store unchanged by unused writes", v, 8'h43);
    rd(2'd2, v); chk("R8 address 2 reads zero", v, 8'h00);
    rd(2'd3, v); chk("R8 address 3 reads zero", v, 8'h00);
  endtask

  task automatic t_rereset();
    logic [7:0] v;
    do_reset();
    rd(2'd0, v); chk("R1 pointer cleared again", v, 8'h00);
    peek(8'hAC, v); chk("R1 written byte cleared", v, 8'h00);
    peek(8'h03, v); chk("R1 tail byte cleared", v, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; chk("R1 rdata in reset", reg_rdata, 8'h00);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_window();
    t_upper_edge();
    t_lower_edge();
    t_tail();
    t_locked();
    t_unused();
    t_rereset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule